// File: doc/BRIEF.md
# DAC Configuration Strobe Sequencer

This block loads a multi-byte configuration word into an external waveform-generating DAC. Each byte goes out over a byte-wide data bus and is latched by a fixed handshake on three pins. The write clock falls first. Strobe A then rises. Strobe B then falls. All three then return to their idle levels together. The DAC sets a lower bound on the time between these edges. The block meets those bounds by holding each phase for a whole number of system clock cycles. No asynchronous delay elements are used.

Each phase length is the ceiling of its nanosecond minimum divided by the clock period. The period is given to the block as a parameter in picoseconds, and every phase lasts at least one cycle. If the clock is made faster, the same parameters produce longer cycle counts, so the handshake keeps its timing. A single-cycle start request captures all configuration bytes at once and begins the sequence. Byte 0 goes out first. A one-cycle done pulse marks the end of the last byte.

Top module: `dacLoadSequencer`

## Requirements
- R1: While reset is asserted and after it is released, the pins show their idle levels: `dacWrClk`=1, `dacStrobeA`=0, `dacStrobeB`=1, `dacData`=0, `busy`=0, `done`=0.
- R2: For each byte, `dacWrClk` falls first, then `dacStrobeA` rises, then `dacStrobeB` falls. `dacStrobeA` is high only while `dacWrClk` is low, and `dacStrobeB` is low only while `dacStrobeA` is high.
- R3: From the cycle in which `dacWrClk` goes low to the cycle in which `dacStrobeA` goes high is exactly ceil(WCLK_TO_A_PS / CLK_PERIOD_PS) cycles, with a minimum of 1. This spacing is at least WCLK_TO_A_PS (default 5 ns).
- R4: From the `dacStrobeA` rise to the `dacStrobeB` fall is exactly ceil(A_TO_B_PS / CLK_PERIOD_PS) cycles, with a minimum of 1. This spacing is at least A_TO_B_PS (default 4 ns).
- R5: `dacData` shows the byte for ceil(SETUP_PS / CLK_PERIOD_PS) cycles before `dacWrClk` falls. It stays unchanged until the strobes have returned to idle and a further ceil(RECOVER_PS / CLK_PERIOD_PS) cycles have passed.
- R6: NUM_BYTES bytes (default 5) go out in order. Byte k is `cfgBytes[k*BYTE_W +: BYTE_W]`, so byte 0 is the lowest bits and goes first. All bytes are captured from `cfgBytes` in the same cycle the start is accepted, and later changes to `cfgBytes` have no effect on that run.
- R7: A `startReq` sampled at a clock edge where `busy` is low is accepted, and `busy` goes high right after that edge. A `startReq` sampled while `busy` is high is ignored and leaves the data bus and the strobe timing of the current run unchanged.
- R8: `done` is high for exactly one cycle. That cycle is the last cycle of `busy`, and it follows the idle-level cycles of the final byte.
- R9: `dacStrobeB` stays low for ceil(HOLD_PS / CLK_PERIOD_PS) cycles before the strobes are released. Every phase, including setup and recovery, lasts at least one cycle.
- R10: Between bytes and after the last byte, all strobes are at their idle levels together. `dacData` returns to 0 once the run is finished.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Start request, sampled on each rising edge |
| cfgBytes | input | NUM_BYTES*BYTE_W | Configuration bytes; byte 0 in the lowest bits |
| dacWrClk | output | 1 | DAC write clock, idle high |
| dacStrobeA | output | 1 | First control strobe, idle low, active high |
| dacStrobeB | output | 1 | Second control strobe, idle high, active low |
| dacData | output | BYTE_W | Byte-wide data bus to the DAC |
| busy | output | 1 | High from an accepted start through the done cycle |
| done | output | 1 | One-cycle pulse at the end of the run |

## Verification
The assertions check every cycle that the strobes never leave their nesting order and that the data bus does not move while the write clock is low. They also check that each strobe edge comes at least the derived number of cycles after the edge before it, and that done is a single pulse inside busy. Only the bench's scenarios can show the rest. That covers the exact cycle counts for a clock period that yields multi-cycle gaps, and that the bytes appear in order and equal the values captured at start. It also covers that a start arriving mid-run, or held high across a finish, is ignored or accepted on exactly the right edge.

// File: rtl/dacLoadPkg.sv
package dacLoadPkg;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_WLOW, PH_AHIGH, PH_BLOW, PH_REL, PH_DONE
  } phase_e;

  // Commands from the control FSM to the pin datapath
  typedef struct packed {
    logic capture;   // latch the configuration bytes
    logic dataOn;    // drive the selected byte onto the bus
    logic wclkLow;   // write clock active (low)
    logic aHigh;     // strobe A active (high)
    logic bLow;      // strobe B active (low)
  } strobeCmd_t;

  // Minimum spacing in ps turned into whole cycles, never less than one
  function automatic int psToCycles(input int ps, input int periodPs);
    int c;
    c = (ps + periodPs - 1) / periodPs;
    if (c < 1) c = 1;
    return c;
  endfunction

endpackage

// File: rtl/dacLoadCtrl.sv
module dacLoadCtrl
  import dacLoadPkg::*;
#(
  parameter int NUM_BYTES = 5,
  parameter int IDX_W     = 3,
  parameter int G_SETUP   = 1,
  parameter int G_WA      = 1,
  parameter int G_AB      = 1,
  parameter int G_HOLD    = 1,
  parameter int G_REC     = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  output strobeCmd_t       cmd,
  output logic [IDX_W-1:0] byteSel,
  output logic             busy,
  output logic             done
);

  localparam int MAX_A = (G_SETUP > G_WA) ? G_SETUP : G_WA;
  localparam int MAX_B = (G_AB > G_HOLD) ? G_AB : G_HOLD;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_G = (MAX_C > G_REC) ? MAX_C : G_REC;
  localparam int CNT_W = $clog2(MAX_G + 1);

  phase_e           state;
  logic [CNT_W-1:0] cnt;
  logic             lastByte;

  function automatic logic [CNT_W-1:0] ld(input int g);
    return CNT_W'(g - 1);
  endfunction

  assign lastByte = (byteSel == IDX_W'(NUM_BYTES - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= PH_IDLE;
      cnt     <= '0;
      byteSel <= '0;
    end else begin
      case (state)
        PH_IDLE: if (startReq) begin
          state   <= PH_SETUP;
          cnt     <= ld(G_SETUP);
          byteSel <= '0;
        end
        PH_SETUP: if (cnt == '0) begin
          state <= PH_WLOW;
          cnt   <= ld(G_WA);
        end else cnt <= cnt - 1'b1;
        PH_WLOW: if (cnt == '0) begin
          state <= PH_AHIGH;
          cnt   <= ld(G_AB);
        end else cnt <= cnt - 1'b1;
        PH_AHIGH: if (cnt == '0) begin
          state <= PH_BLOW;
          cnt   <= ld(G_HOLD);
        end else cnt <= cnt - 1'b1;
        PH_BLOW: if (cnt == '0) begin
          state <= PH_REL;
          cnt   <= ld(G_REC);
        end else cnt <= cnt - 1'b1;
        PH_REL: if (cnt == '0) begin
          if (lastByte) state <= PH_DONE;
          else begin
            state   <= PH_SETUP;
            cnt     <= ld(G_SETUP);
            byteSel <= byteSel + 1'b1;
          end
        end else cnt <= cnt - 1'b1;
        PH_DONE: state <= PH_IDLE;
        default: state <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd         = '0;
    cmd.capture = (state == PH_IDLE) && startReq;
    cmd.dataOn  = state inside {PH_SETUP, PH_WLOW, PH_AHIGH, PH_BLOW, PH_REL};
    cmd.wclkLow = state inside {PH_WLOW, PH_AHIGH, PH_BLOW};
    cmd.aHigh   = state inside {PH_AHIGH, PH_BLOW};
    cmd.bLow    = (state == PH_BLOW);
  end

  assign busy = (state != PH_IDLE);
  assign done = (state == PH_DONE);

  // R8: done is a single-cycle pulse inside busy
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_done_in_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);
  // R7: busy only rises after a start, and a start while idle is taken
  p_busy_from_start_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startReq));
  p_start_taken_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startReq) |=> busy);
  p_busy_holds_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

endmodule

// File: rtl/dacLoadPath.sv
module dacLoadPath
  import dacLoadPkg::*;
#(
  parameter int NUM_BYTES = 5,
  parameter int BYTE_W    = 8,
  parameter int IDX_W     = 3,
  parameter int G_WA      = 1,
  parameter int G_AB      = 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  strobeCmd_t                  cmd,
  input  logic [IDX_W-1:0]            byteSel,
  input  logic [NUM_BYTES*BYTE_W-1:0] cfgBytes,
  output logic                        dacWrClk,
  output logic                        dacStrobeA,
  output logic                        dacStrobeB,
  output logic [BYTE_W-1:0]           dacData
);

  logic [BYTE_W-1:0] held [NUM_BYTES];

  always_ff @(posedge clk) begin
    if (cmd.capture) begin
      for (int i = 0; i < NUM_BYTES; i++)
        held[i] <= cfgBytes[i*BYTE_W +: BYTE_W];
    end
  end

  // Registered pins: glitch-free strobes, one cycle behind the FSM
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dacWrClk   <= 1'b1;
      dacStrobeA <= 1'b0;
      dacStrobeB <= 1'b1;
      dacData    <= '0;
    end else begin
      dacWrClk   <= !cmd.wclkLow;
      dacStrobeA <= cmd.aHigh;
      dacStrobeB <= !cmd.bLow;
      dacData    <= cmd.dataOn ? held[byteSel] : '0;
    end
  end

  // Run-length counters used only by the spacing assertions
  logic [15:0] lowRun, highRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowRun  <= '0;
      highRun <= '0;
    end else begin
      lowRun  <= dacWrClk ? '0 : ((&lowRun) ? lowRun : lowRun + 1'b1);
      highRun <= !dacStrobeA ? '0 : ((&highRun) ? highRun : highRun + 1'b1);
    end
  end

  p_a_inside_wclk_r2: assert property (@(posedge clk) disable iff (!rstN)
    dacStrobeA |-> !dacWrClk);
  p_b_inside_a_r2: assert property (@(posedge clk) disable iff (!rstN)
    !dacStrobeB |-> dacStrobeA);
  p_gap_wa_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dacStrobeA) |-> (lowRun >= 16'(G_WA)));
  p_gap_ab_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dacStrobeB) |-> (highRun >= 16'(G_AB)));
  p_data_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    !dacWrClk |-> $stable(dacData));

endmodule

// File: rtl/dacLoadSequencer.sv
module dacLoadSequencer
  import dacLoadPkg::*;
#(
  parameter int NUM_BYTES     = 5,
  parameter int BYTE_W        = 8,
  parameter int CLK_PERIOD_PS = 10000,
  parameter int SETUP_PS      = 2000,
  parameter int WCLK_TO_A_PS  = 5000,
  parameter int A_TO_B_PS     = 4000,
  parameter int HOLD_PS       = 3000,
  parameter int RECOVER_PS    = 2000
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        startReq,
  input  logic [NUM_BYTES*BYTE_W-1:0] cfgBytes,
  output logic                        dacWrClk,
  output logic                        dacStrobeA,
  output logic                        dacStrobeB,
  output logic [BYTE_W-1:0]           dacData,
  output logic                        busy,
  output logic                        done
);

  localparam int IDX_W   = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;
  localparam int G_SETUP = psToCycles(SETUP_PS, CLK_PERIOD_PS);
  localparam int G_WA    = psToCycles(WCLK_TO_A_PS, CLK_PERIOD_PS);
  localparam int G_AB    = psToCycles(A_TO_B_PS, CLK_PERIOD_PS);
  localparam int G_HOLD  = psToCycles(HOLD_PS, CLK_PERIOD_PS);
  localparam int G_REC   = psToCycles(RECOVER_PS, CLK_PERIOD_PS);

  strobeCmd_t       cmd;
  logic [IDX_W-1:0] byteSel;

  dacLoadCtrl #(
    .NUM_BYTES(NUM_BYTES), .IDX_W(IDX_W), .G_SETUP(G_SETUP), .G_WA(G_WA),
    .G_AB(G_AB), .G_HOLD(G_HOLD), .G_REC(G_REC)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .cmd(cmd),
    .byteSel(byteSel), .busy(busy), .done(done)
  );

  dacLoadPath #(
    .NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W), .IDX_W(IDX_W),
    .G_WA(G_WA), .G_AB(G_AB)
  ) i_path (
    .clk(clk), .rstN(rstN), .cmd(cmd), .byteSel(byteSel), .cfgBytes(cfgBytes),
    .dacWrClk(dacWrClk), .dacStrobeA(dacStrobeA), .dacStrobeB(dacStrobeB),
    .dacData(dacData)
  );

endmodule

// File: tb/test_dacLoadSequencer.sv
`timescale 1ps/1ps
module test_dacLoadSequencer;

  localparam int CLK_PS = 2000;
  localparam int NB     = 5;
  localparam int BW     = 8;

  function automatic int cyc(input int ps);
    int c;
    c = (ps + CLK_PS - 1) / CLK_PS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int GS = cyc(2000), GWA = cyc(5000), GAB = cyc(4000);
  localparam int GH = cyc(3000), GR = cyc(2000);

  logic clk = 1'b0, rstN = 1'b0, startReq = 1'b0;
  logic [NB*BW-1:0] cfgBytes = '0;
  logic dacWrClk, dacStrobeA, dacStrobeB, busy, done;
  logic [BW-1:0] dacData;

  int checks = 0, errors = 0, cycle = 0;
  bit finished = 0;

  dacLoadSequencer #(.NUM_BYTES(NB), .BYTE_W(BW), .CLK_PERIOD_PS(CLK_PS)) i_dacLoadSequencer (
    .clk(clk), .rstN(rstN), .startReq(startReq), .cfgBytes(cfgBytes),
    .dacWrClk(dacWrClk), .dacStrobeA(dacStrobeA), .dacStrobeB(dacStrobeB),
    .dacData(dacData), .busy(busy), .done(done));

  always #(CLK_PS/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cycle, act, exp);
    end
  endtask

  // Reference model: one queue entry per busy cycle, code = byte*8 + phase
  // phase 1 setup, 2 wclk low, 3 A high, 4 B low, 5 release, 6 done
  int q[$];
  int cur = 0, prev = 0;
  bit wasBusy;
  logic [BW-1:0] capt [NB];

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      q.delete(); cur = 0; prev = 0;
    end else begin
      wasBusy = (cur != 0);
      prev = cur;
      cur = (q.size() > 0) ? q.pop_front() : 0;
      if (!wasBusy && startReq) begin
        for (int b = 0; b < NB; b++) begin
          capt[b] = cfgBytes[b*BW +: BW];
          repeat (GS)  q.push_back(b*8 + 1);
          repeat (GWA) q.push_back(b*8 + 2);
          repeat (GAB) q.push_back(b*8 + 3);
          repeat (GH)  q.push_back(b*8 + 4);
          repeat (GR)  q.push_back(b*8 + 5);
        end
        q.push_back(6);
        cur = q.pop_front();
      end
    end
  end

  // Per-cycle comparison plus edge-spacing measurement
  int fallCyc = 0, riseCyc = 0;
  logic lastWr = 1'b1, lastA = 1'b0, lastB = 1'b1;
  always @(negedge clk) begin
    int pp, pb;
    logic eWr, eA, eB;
    logic [BW-1:0] eData;
    cycle++;
    if (rstN && !finished) begin
      pp = prev % 8; pb = prev / 8;
      eWr = !(pp inside {2, 3, 4});
      eA  = pp inside {3, 4};
      eB  = (pp != 4);
      eData = (pp >= 1 && pp <= 5) ? capt[pb] : '0;
      chk(busy == (cur != 0), "R7 busy", busy, cur != 0);
      chk(done == ((cur % 8) == 6), "R8 done", done, (cur % 8) == 6);
      chk({dacWrClk, dacStrobeA, dacStrobeB} == {eWr, eA, eB}, "R2/R9/R10 strobes",
          {dacWrClk, dacStrobeA, dacStrobeB}, {eWr, eA, eB});
      chk(dacData == eData, "R5/R6 data", dacData, eData);
      if (lastWr && !dacWrClk) fallCyc = cycle;
      if (!lastA && dacStrobeA) begin
        chk((cycle - fallCyc) == GWA, "R3 cycles", cycle - fallCyc, GWA);
        chk((cycle - fallCyc) * CLK_PS >= 5000, "R3 min ns", (cycle - fallCyc) * CLK_PS, 5000);
        riseCyc = cycle;
      end
      if (lastB && !dacStrobeB) begin
        chk((cycle - riseCyc) == GAB, "R4 cycles", cycle - riseCyc, GAB);
        chk((cycle - riseCyc) * CLK_PS >= 4000, "R4 min ns", (cycle - riseCyc) * CLK_PS, 4000);
      end
      lastWr = dacWrClk; lastA = dacStrobeA; lastB = dacStrobeB;
    end
  end

  task automatic pulseStart(input logic [NB*BW-1:0] cfg);
    @(negedge clk);
    cfgBytes = cfg; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  task automatic waitIdle();
    do @(negedge clk); while (busy);
    repeat (2) @(negedge clk);
  endtask

  task automatic summary();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PS * 60000);
    errors++;
    $display("FAIL watchdog expired at cycle %0d: actual hung expected idle", cycle);
    summary();
  end

  initial begin
    // R1: idle levels during reset and just after release
    repeat (3) @(negedge clk);
    chk({dacWrClk, dacStrobeA, dacStrobeB, busy, done} == 5'b10100, "R1 reset pins",
        {dacWrClk, dacStrobeA, dacStrobeB, busy, done}, 5'b10100);
    chk(dacData == 0, "R1 reset data", dacData, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk({dacWrClk, dacStrobeA, dacStrobeB, busy, done} == 5'b10100, "R1 after release",
        {dacWrClk, dacStrobeA, dacStrobeB, busy, done}, 5'b10100);

    // R6: ordinary run with distinct bytes
    pulseStart(40'h55_44_33_22_11);
    waitIdle();

    // R7: start and new cfg mid-run are ignored; R6 cfg change has no effect
    pulseStart(40'h01_5A_A5_FF_00);
    repeat (10) @(negedge clk);
    cfgBytes = 40'hDE_AD_BE_EF_77; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    repeat (5) @(negedge clk);
    cfgBytes = 40'h12_34_56_78_9A;
    waitIdle();

    // R7/R8: start held high, back-to-back runs accepted when busy drops
    @(negedge clk);
    cfgBytes = 40'h80_40_20_10_08; startReq = 1'b1;
    repeat (60) @(negedge clk);
    cfgBytes = 40'hF0_E1_D2_C3_B4;
    do @(negedge clk); while (!done);
    @(negedge clk);
    startReq = 1'b0;
    waitIdle();

    // R10: back at idle levels at the end
    chk({dacWrClk, dacStrobeA, dacStrobeB} == 3'b101, "R10 final idle",
        {dacWrClk, dacStrobeA, dacStrobeB}, 3'b101);
    summary();
  end

endmodule